// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block lets on-chip logic program one byte, erase one sector or erase a whole external byte-wide flash device without knowing the command protocol. A single-cycle start pulse carries an opcode, a target address and a data byte. The sequencer then plays the fixed unlock-and-command write cycles onto the flash bus. The write strobe timing is set by parameters counted in clock cycles.

After the last command write, the block reads the target address over and over until the device reports that it has finished. The caller picks one of two completion checks with a select input. The first compares bit 7 of each read with the expected final value. The second waits until bit 6 stops changing between two reads in a row. Each operation kind has its own time limit in clock cycles. If the limit runs out, the sequencer writes the read-mode reset command and reports an error.

Top module: `flash_seq`

## Requirements
- R1: Opcode 0 (byte program) produces exactly four write cycles, in order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R2: Opcodes 1 (sector erase) and 2 (chip erase) produce exactly six write cycles, in order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. The sixth is 30h at the request address for a sector erase, or 10h at 5555h for a chip erase.
- R3: Each write holds the write strobe low for WE_LOW_CYC cycles and high for WE_HIGH_CYC cycles before the next bus action. Output-enable stays high while the strobe is low. Address and driven data stay unchanged from the falling edge through the rising edge of the strobe.
- R4: With pollSel = 0, polling ends with done when bit 7 of a read equals bit 7 of the programmed byte, or equals 1 after an erase.
- R5: With pollSel = 1, polling ends with done when bit 6 has the same value in two reads in a row.
- R6: If completion is not seen within PROG_TMO, SECT_TMO or CHIP_TMO cycles (chosen by the opcode) of polling, the block writes F0h at address 0 and then raises error instead of done.
- R7: busy is high from the cycle after an accepted start until the cycle in which done or error is raised. done and error are single-cycle pulses and are never high together.
- R8: A start pulse while busy is high is ignored. It adds no bus cycle and does not change the running operation.
- R9: The block drives the data bus during write cycles and releases it to high impedance while output-enable is low.
- R10: After reset, busy, done and error are low, and chip-select, output-enable and write strobe are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, one cycle |
| opcode | input | 2 | 0 byte program, 1 sector erase, 2 chip erase |
| addrIn | input | ADDR_W | Target byte or sector address |
| dataIn | input | 8 | Byte to program |
| pollSel | input | 1 | 0 bit-7 data check, 1 bit-6 toggle check |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished, one-cycle pulse |
| error | output | 1 | Timeout and recovery finished, one-cycle pulse |
| flashCsN | output | 1 | Flash chip select, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write strobe, active low |
| flashAddr | output | ADDR_W | Flash address |
| flashDq | inout | 8 | Flash data bus |

## Verification
The checker watches several rules on every clock. Output-enable must never be low while the write strobe is low. Address and data must hold steady across the strobe's rising edge. Bus drive must follow the direction of the bus cycle. The outcome pulses must last one cycle, and the bus must be idle whenever busy is low. Only the bench's scenarios can show the exact command bytes and addresses of each sequence and the measured strobe width. They also show which completion check ends each poll, that the time limit depends on the opcode, that the reset command appears after a timeout, and that a start pulse during an operation is dropped. A behavioural flash model in the bench supplies the status reads for these scenarios.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [1:0] OP_PROG = 2'd0;

  typedef struct packed {
    logic load;        // capture request, set up first command
    logic stepAdv;     // move to next command write
    logic pollStart;   // point bus at target, clear timer and reads
    logic rdSample;    // capture data bus at end of read
    logic abortLoad;   // set up read-mode reset write
    logic pollActive;  // timer runs
    logic clrPhase;    // restart phase counter
  } seqCtrl_t;

  function automatic logic [31:0] cmdAddr(input logic [1:0] op, input logic [2:0] step,
                                          input logic [31:0] addr);
    logic [31:0] a;
    if (op == OP_PROG) begin
      case (step)
        3'd0, 3'd2: a = 32'h5555;
        3'd1:       a = 32'h2AAA;
        default:    a = addr;
      endcase
    end else begin
      case (step)
        3'd0, 3'd2, 3'd3: a = 32'h5555;
        3'd1, 3'd4:       a = 32'h2AAA;
        default:          a = op[1] ? 32'h5555 : addr;
      endcase
    end
    return a;
  endfunction

  function automatic logic [7:0] cmdData(input logic [1:0] op, input logic [2:0] step,
                                         input logic [7:0] data);
    logic [7:0] d;
    if (op == OP_PROG) begin
      case (step)
        3'd0:    d = 8'hAA;
        3'd1:    d = 8'h55;
        3'd2:    d = 8'hA0;
        default: d = data;
      endcase
    end else begin
      case (step)
        3'd0, 3'd3: d = 8'hAA;
        3'd1, 3'd4: d = 8'h55;
        3'd2:       d = 8'h80;
        default:    d = op[1] ? 8'h10 : 8'h30;
      endcase
    end
    return d;
  endfunction

  function automatic logic cmdLast(input logic [1:0] op, input logic [2:0] step);
    return (op == OP_PROG) ? (step == 3'd3) : (step == 3'd5);
  endfunction

endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int PH_W     = 4,
  parameter int PROG_TMO = 7000,
  parameter int SECT_TMO = 2000000,
  parameter int CHIP_TMO = 600000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctl,
  input  logic [1:0]        opIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              pollSel,
  input  logic [7:0]        dqIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busData,
  output logic [PH_W-1:0]   phaseCnt,
  output logic              lastStep,
  output logic              pollOk,
  output logic              tmoHit,
  output logic              abortFlag
);
  localparam int TMO_MAX = (CHIP_TMO > SECT_TMO)
                           ? ((CHIP_TMO > PROG_TMO) ? CHIP_TMO : PROG_TMO)
                           : ((SECT_TMO > PROG_TMO) ? SECT_TMO : PROG_TMO);
  localparam int TMO_W = $clog2(TMO_MAX + 1);

  logic [1:0]        opReg;
  logic [ADDR_W-1:0] tgtAddr;
  logic [7:0]        tgtData;
  logic              modeReg;
  logic [2:0]        step;
  logic [TMO_W-1:0]  tmoCnt, tmoLimit;
  logic [7:0]        rdCur, rdPrev;
  logic [1:0]        nReads;
  logic              expect7;

  always_comb begin
    case (opReg)
      2'd0:    tmoLimit = TMO_W'(PROG_TMO);
      2'd1:    tmoLimit = TMO_W'(SECT_TMO);
      default: tmoLimit = TMO_W'(CHIP_TMO);
    endcase
  end

  assign tmoHit   = (tmoCnt >= tmoLimit);
  assign lastStep = cmdLast(opReg, step);
  assign expect7  = (opReg == OP_PROG) ? tgtData[7] : 1'b1;
  assign pollOk   = modeReg ? ((nReads == 2'd2) && (rdCur[6] == rdPrev[6]))
                            : (rdCur[7] == expect7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= '0; tgtAddr <= '0; tgtData <= '0; modeReg <= 1'b0; step <= '0;
      busAddr <= '0; busData <= '0; phaseCnt <= '0; tmoCnt <= '0;
      rdCur <= '0; rdPrev <= '0; nReads <= '0; abortFlag <= 1'b0;
    end else begin
      phaseCnt <= ctl.clrPhase ? '0 : phaseCnt + 1'b1;
      if (ctl.load) begin
        opReg     <= opIn;
        tgtAddr   <= addrIn;
        tgtData   <= dataIn;
        modeReg   <= pollSel;
        step      <= '0;
        abortFlag <= 1'b0;
        busAddr   <= ADDR_W'(cmdAddr(opIn, 3'd0, 32'(addrIn)));
        busData   <= cmdData(opIn, 3'd0, dataIn);
      end
      if (ctl.stepAdv) begin
        step    <= step + 3'd1;
        busAddr <= ADDR_W'(cmdAddr(opReg, step + 3'd1, 32'(tgtAddr)));
        busData <= cmdData(opReg, step + 3'd1, tgtData);
      end
      if (ctl.pollStart) begin
        busAddr <= tgtAddr;
        tmoCnt  <= '0;
        nReads  <= '0;
      end else if (ctl.pollActive && !tmoHit) begin
        tmoCnt <= tmoCnt + 1'b1;
      end
      if (ctl.rdSample) begin
        rdPrev <= rdCur;
        rdCur  <= dqIn;
        nReads <= (nReads == 2'd2) ? 2'd2 : nReads + 2'd1;
      end
      if (ctl.abortLoad) begin
        busAddr   <= '0;
        busData   <= 8'hF0;
        abortFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int PH_W        = 4,
  parameter int WE_LOW_CYC  = 7,
  parameter int WE_HIGH_CYC = 4,
  parameter int RD_LOW_CYC  = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [PH_W-1:0] phaseCnt,
  input  logic            lastStep,
  input  logic            pollOk,
  input  logic            tmoHit,
  input  logic            abortFlag,
  output seqCtrl_t        ctl,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic            weLow,
  output logic            oeLow,
  output logic            dqDrive
);
  typedef enum logic [2:0] {S_IDLE, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH} seqState_e;
  seqState_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        ctl.load = 1'b1; ctl.clrPhase = 1'b1; nextState = S_WLOW;
      end
      S_WLOW: if (phaseCnt == PH_W'(WE_LOW_CYC - 1)) begin
        ctl.clrPhase = 1'b1; nextState = S_WHIGH;
      end
      S_WHIGH: if (phaseCnt == PH_W'(WE_HIGH_CYC - 1)) begin
        ctl.clrPhase = 1'b1;
        if (abortFlag)     nextState = S_IDLE;
        else if (lastStep) begin ctl.pollStart = 1'b1; nextState = S_RLOW; end
        else               begin ctl.stepAdv = 1'b1; nextState = S_WLOW; end
      end
      S_RLOW: begin
        ctl.pollActive = 1'b1;
        if (phaseCnt == PH_W'(RD_LOW_CYC - 1)) begin
          ctl.rdSample = 1'b1; ctl.clrPhase = 1'b1; nextState = S_RHIGH;
        end
      end
      S_RHIGH: begin
        ctl.pollActive = 1'b1;
        ctl.clrPhase   = 1'b1;
        if (pollOk)      nextState = S_IDLE;
        else if (tmoHit) begin ctl.abortLoad = 1'b1; nextState = S_WLOW; end
        else             nextState = S_RLOW;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; done <= 1'b0; error <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == S_RHIGH) && (nextState == S_IDLE);
      error <= (state == S_WHIGH) && (nextState == S_IDLE);
    end
  end

  assign busy    = (state != S_IDLE);
  assign weLow   = (state == S_WLOW);
  assign oeLow   = (state == S_RLOW);
  assign dqDrive = (state == S_WLOW) || (state == S_WHIGH);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int WE_LOW_CYC  = 7,
  parameter int WE_HIGH_CYC = 4,
  parameter int RD_LOW_CYC  = 14,
  parameter int PROG_TMO    = 7000,
  parameter int SECT_TMO    = 2000000,
  parameter int CHIP_TMO    = 600000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              pollSel,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              flashCsN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic [ADDR_W-1:0] flashAddr,
  inout  wire  [7:0]        flashDq
);
  localparam int PH_MAX = (WE_LOW_CYC > WE_HIGH_CYC)
                          ? ((WE_LOW_CYC > RD_LOW_CYC) ? WE_LOW_CYC : RD_LOW_CYC)
                          : ((WE_HIGH_CYC > RD_LOW_CYC) ? WE_HIGH_CYC : RD_LOW_CYC);
  localparam int PH_W = $clog2(PH_MAX + 1);

  seqCtrl_t          ctl;
  logic [PH_W-1:0]   phaseCnt;
  logic              lastStep, pollOk, tmoHit, abortFlag;
  logic              weLow, oeLow, dqDrive;
  logic [7:0]        busData;
  logic [ADDR_W-1:0] busAddr;

  flash_seq_ctrl #(.PH_W(PH_W), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC),
                   .RD_LOW_CYC(RD_LOW_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .phaseCnt(phaseCnt), .lastStep(lastStep),
    .pollOk(pollOk), .tmoHit(tmoHit), .abortFlag(abortFlag), .ctl(ctl), .busy(busy),
    .done(done), .error(error), .weLow(weLow), .oeLow(oeLow), .dqDrive(dqDrive));

  flash_seq_dp #(.ADDR_W(ADDR_W), .PH_W(PH_W), .PROG_TMO(PROG_TMO), .SECT_TMO(SECT_TMO),
                 .CHIP_TMO(CHIP_TMO)) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opIn(opcode), .addrIn(addrIn), .dataIn(dataIn),
    .pollSel(pollSel), .dqIn(flashDq), .busAddr(busAddr), .busData(busData),
    .phaseCnt(phaseCnt), .lastStep(lastStep), .pollOk(pollOk), .tmoHit(tmoHit),
    .abortFlag(abortFlag));

  assign flashCsN  = !busy;
  assign flashWeN  = !weLow;
  assign flashOeN  = !oeLow;
  assign flashAddr = busAddr;
  assign flashDq   = dqDrive ? busData : 8'bz;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              flashCsN,
  input logic              flashOeN,
  input logic              flashWeN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [7:0]        busData,
  input logic              dqDrive
);
  assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> flashOeN);

  assert_hold_at_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> ($stable(flashAddr) && $stable(busData) && dqDrive));

  assert_drive_in_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> dqDrive);

  assert_release_in_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> !dqDrive);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_error_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    error |=> !error);

  assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (flashCsN && flashOeN && flashWeN));
endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .error(error),
  .flashCsN(flashCsN), .flashOeN(flashOeN), .flashWeN(flashWeN),
  .flashAddr(flashAddr), .busData(busData), .dqDrive(dqDrive));

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
  localparam int AW = 18, WL = 3, WH = 2, RL = 2, PT = 150, ST = 250, CT = 350;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, pollSel = 1'b0;
  logic [1:0] opcode = '0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic busy, done, error, flashCsN, flashOeN, flashWeN;
  logic [AW-1:0] flashAddr;
  wire  [7:0] flashDq;

  flash_seq #(.ADDR_W(AW), .WE_LOW_CYC(WL), .WE_HIGH_CYC(WH), .RD_LOW_CYC(RL),
              .PROG_TMO(PT), .SECT_TMO(ST), .CHIP_TMO(CT)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .addrIn(addrIn),
    .dataIn(dataIn), .pollSel(pollSel), .busy(busy), .done(done), .error(error),
    .flashCsN(flashCsN), .flashOeN(flashOeN), .flashWeN(flashWeN),
    .flashAddr(flashAddr), .flashDq(flashDq));

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit started = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Flash model: status reads while busy, final byte afterwards
  int mdlBusy = 0;
  logic [7:0] finalByte = 8'hFF;
  logic togBit = 1'b0;
  logic [7:0] mdlVal;
  always_comb mdlVal = (mdlBusy > 0) ? {~finalByte[7], togBit, finalByte[5:0]} : finalByte;
  assign flashDq = (!flashCsN && !flashOeN) ? mdlVal : 8'bz;
  always @(posedge flashOeN) if (started) begin
    if (mdlBusy > 0) mdlBusy--;
    togBit = ~togBit;
  end

  // Scoreboard of bus writes
  typedef struct { logic [AW-1:0] a; logic [7:0] d; } wr_t;
  wr_t expQ[$];
  int wrCount = 0, weLowCnt = 0, lastRise = 0, prevRise = 0;
  bit rdChecked = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!flashWeN) weLowCnt++;
    if (!flashOeN && !rdChecked) begin
      rdChecked = 1;
      check(flashDq === mdlVal && flashWeN, "R9 read bus", flashDq, mdlVal);
    end
    if (flashOeN) rdChecked = 0;
  end

  always @(posedge flashWeN) if (started) begin
    wr_t e;
    wrCount++;
    prevRise = lastRise;
    lastRise = cyc;
    check(weLowCnt == WL, "R3 strobe low width", weLowCnt, WL);
    weLowCnt = 0;
    if (expQ.size() == 0) check(0, "R1/R2 unexpected write", flashAddr, 0);
    else begin
      e = expQ.pop_front();
      check(flashAddr == e.a && flashDq == e.d, "R1/R2 write addr,data",
            {flashAddr, flashDq}, {e.a, e.d});
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
    wr_t e; e.a = a; e.d = d; expQ.push_back(e);
  endtask

  task automatic runOp(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input bit mode, input int busyReads, input bit expErr,
                       input bit pokeStart);
    int nExp, w0, tmo;
    bit gotDone = 0, gotErr = 0;
    push(AW'(18'h05555), 8'hAA); push(AW'(18'h02AAA), 8'h55);
    if (op == 2'd0) begin
      push(AW'(18'h05555), 8'hA0); push(a, d); nExp = 4; tmo = PT;
    end else begin
      push(AW'(18'h05555), 8'h80); push(AW'(18'h05555), 8'hAA); push(AW'(18'h02AAA), 8'h55);
      if (op == 2'd2) begin push(AW'(18'h05555), 8'h10); tmo = CT; end
      else begin push(a, 8'h30); tmo = ST; end
      nExp = 6;
    end
    if (expErr) begin push('0, 8'hF0); nExp++; end
    mdlBusy = busyReads; finalByte = (op == 2'd0) ? d : 8'hFF; togBit = 1'b0;
    w0 = wrCount;
    @(negedge clk);
    start = 1; opcode = op; addrIn = a; dataIn = d; pollSel = mode;
    @(negedge clk);
    start = 0; opcode = 2'd3; addrIn = '1; dataIn = 8'h00; pollSel = ~mode;
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    if (pokeStart) begin
      repeat (5) @(negedge clk);
      start = 1; opcode = 2'd2;
      @(negedge clk);
      start = 0;
    end
    for (int i = 0; i < 20000 && !gotDone && !gotErr; i++) begin
      @(negedge clk);
      gotDone = done; gotErr = error;
    end
    if (expErr) begin
      check(gotErr && !gotDone, "R6 timeout error", gotErr, 1);
      check(cyc - prevRise >= tmo, "R6 time limit respected", cyc - prevRise, tmo);
    end else if (mode)
      check(gotDone && !gotErr, "R5 toggle completion", gotDone, 1);
    else
      check(gotDone && !gotErr, "R4 data-poll completion", gotDone, 1);
    check(busy == 1'b0, "R7 busy low with outcome", busy, 0);
    @(negedge clk);
    check(!done && !error, "R7 one-cycle pulse", {done, error}, 0);
    check(wrCount - w0 == nExp && expQ.size() == 0,
          pokeStart ? "R8 start ignored while busy" : (op == 2'd0 ? "R1 write count" : "R2 write count"),
          wrCount - w0, nExp);
    expQ.delete();
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    started = 1;
    check(!busy && !done && !error, "R10 reset outputs", {busy, done, error}, 0);
    check(flashCsN && flashOeN && flashWeN, "R10 reset bus pins",
          {flashCsN, flashOeN, flashWeN}, 3'b111);
    runOp(2'd0, 18'h1_2345, 8'h5A, 1'b0, 3, 1'b0, 1'b0);   // R1 R4 bit7=0
    runOp(2'd0, 18'h0_0F0F, 8'hC3, 1'b0, 2, 1'b0, 1'b0);   // R4 bit7=1
    runOp(2'd0, 18'h3_C001, 8'h3C, 1'b1, 4, 1'b0, 1'b0);   // R5
    runOp(2'd1, 18'h2_4600, 8'h00, 1'b0, 5, 1'b0, 1'b0);   // R2 sector, R4 erase
    runOp(2'd2, 18'h0_0000, 8'h00, 1'b1, 6, 1'b0, 1'b0);   // R2 chip, R5
    runOp(2'd0, 18'h0_1111, 8'h81, 1'b0, 100000, 1'b1, 1'b0); // R6 program limit
    runOp(2'd1, 18'h1_0200, 8'h00, 1'b1, 100000, 1'b1, 1'b0); // R6 sector limit
    runOp(2'd2, 18'h0_0000, 8'h00, 1'b0, 100000, 1'b1, 1'b0); // R6 chip limit
    runOp(2'd0, 18'h2_2222, 8'h77, 1'b0, 3, 1'b0, 1'b1);   // R8
    runOp(2'd0, 18'h0_0005, 8'hFE, 1'b1, 2, 1'b0, 1'b0);   // recovery after error
    finish();
  end
endmodule